// File: doc/BRIEF.md
# Fractional Oversampling Tick Generator

This block derives a one-clock enable pulse at a serial receiver's oversampling rate from a faster system clock. The ratio between the two rates is not a whole number. With a 100 MHz clock, 115200 baud and eight samples per bit, the ideal spacing is about 108.507 clocks. A single integer divider would let the sample point slide steadily through a character.

The generator instead alternates between two terminal counts. Every tick inside an even-numbered bit is spaced by the shorter count (108 by default). Every tick inside an odd-numbered bit is spaced by the longer count (109). Each pair of bits therefore averages 108.5 clocks per tick.

The bit index is derived internally by counting ticks, eight to a bit. An alignment input restarts both the period counter and the bit index. A receiver pulses it on a detected start edge, so the tick grid begins in phase with the incoming character.

Top module: `frac_tick_gen`

## Requirements
- R1: While `rst` is high, `tick` is low on the following cycle. After the last clock edge that samples `rst` high, the first tick rises exactly SHORT_CNT (108) clocks later.
- R2: Each tick is high for exactly one clock cycle.
- R3: Counting bits from 0 after alignment or reset, every tick in an even-numbered bit (ticks 1 to 8, 17 to 24, …) follows the previous tick, or the alignment edge, by exactly SHORT_CNT (108) clocks.
- R4: Every tick in an odd-numbered bit (ticks 9 to 16, 25 to 32, …) follows the previous tick by exactly LONG_CNT (109) clocks. No gap ever exceeds LONG_CNT.
- R5: A clock edge that samples `align` high clears the period counter and the bit index from any phase. `tick` is low on the next cycle, and the next tick rises exactly SHORT_CNT clocks after that edge.
- R6: While `align` stays high, no tick is produced.
- R7: Across a 10-bit frame (80 ticks) after alignment, the time of tick k differs from k × (100 MHz / 921600 Hz) clock periods by less than one ideal tick period.
- R8: A reset applied mid-stream suppresses ticks for as long as it is held. It restarts the grid exactly as alignment does.
- R9: Over every pair of consecutive bits (16 ticks), the total spacing lies between 16 × 108 and 16 × 109 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| align | input | 1 | Restarts the tick grid and the bit index (start-edge alignment) |
| tick | output | 1 | One-cycle oversampling enable, registered |

## Verification
The bound checker checks several properties on every cycle:
- tick silence during reset and in the cycle after alignment;
- the one-cycle pulse width;
- each gap against the short/long pattern implied by the tick's position in the bit pair;
- that no gap ever runs past the long count.

Only the bench scenarios can show the accumulated drift against the ideal fractional grid over a whole frame. The same holds for the per-pair totals and for restarting from an odd bit, a long held alignment or a reset in mid-stream.

// File: rtl/frac_tick_pkg.sv
package frac_tick_pkg;

  // Phase of the bit being sampled, counted from the last alignment.
  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } bit_phase_e;

  // Width able to hold values 0..v-1, never below one bit.
  function automatic int unsigned width_for(input int unsigned v);
    int unsigned w;
    w = $clog2(v);
    return (w < 1) ? 1 : w;
  endfunction

endpackage

// File: rtl/tick_period_counter.sv
// Free-running period counter with a run-time terminal count.
module tick_period_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic [CNT_W-1:0] term,
  output logic             wrap
);

  logic [CNT_W-1:0] cnt_q;

  // The ">=" compare also recovers if the terminal count shrinks mid-period.
  assign wrap = !rst && !clear && (cnt_q >= term - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt_q <= '0;
    end else if (wrap) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/bit_phase_tracker.sv
// Counts ticks inside a bit and flips the even/odd bit phase on each bit boundary.
module bit_phase_tracker
  import frac_tick_pkg::*;
#(
  parameter int unsigned TICKS_PER_BIT = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       advance,
  output bit_phase_e phase
);

  localparam int unsigned SUB_W = width_for(TICKS_PER_BIT);
  localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(TICKS_PER_BIT - 1);

  logic [SUB_W-1:0] sub_q;
  bit_phase_e       phase_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      sub_q   <= '0;
      phase_q <= PH_EVEN;
    end else if (advance) begin
      if (sub_q == SUB_LAST) begin
        sub_q   <= '0;
        phase_q <= (phase_q == PH_EVEN) ? PH_ODD : PH_EVEN;
      end else begin
        sub_q <= sub_q + SUB_W'(1);
      end
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/term_select.sv
// Maps the bit phase onto one of the two terminal counts.
module term_select
  import frac_tick_pkg::*;
#(
  parameter int unsigned CNT_W         = 7,
  parameter int unsigned SHORT_CNT     = 108,
  parameter int unsigned LONG_CNT      = 109,
  parameter bit          SHORT_ON_EVEN = 1'b1
) (
  input  bit_phase_e       phase,
  output logic [CNT_W-1:0] term
);

  localparam logic [CNT_W-1:0] T_SHORT = CNT_W'(SHORT_CNT);
  localparam logic [CNT_W-1:0] T_LONG  = CNT_W'(LONG_CNT);

  generate
    if (SHORT_ON_EVEN) begin : g_short_even
      assign term = (phase == PH_EVEN) ? T_SHORT : T_LONG;
    end else begin : g_short_odd
      assign term = (phase == PH_EVEN) ? T_LONG : T_SHORT;
    end
  endgenerate

endmodule

// File: rtl/frac_tick_gen.sv
// Fractional-rate oversampling tick generator (top).
module frac_tick_gen
  import frac_tick_pkg::*;
#(
  parameter int unsigned SHORT_CNT     = 108,
  parameter int unsigned LONG_CNT      = 109,
  parameter int unsigned TICKS_PER_BIT = 8,
  parameter bit          SHORT_ON_EVEN = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic align,
  output logic tick
);

  localparam int unsigned MAX_CNT = (LONG_CNT > SHORT_CNT) ? LONG_CNT : SHORT_CNT;
  localparam int unsigned CNT_W   = width_for(MAX_CNT + 1);

  logic             wrap;
  logic [CNT_W-1:0] term;
  bit_phase_e       phase;
  logic             tick_q;

  tick_period_counter #(
    .CNT_W (CNT_W)
  ) u_counter (
    .clk   (clk),
    .rst   (rst),
    .clear (align),
    .term  (term),
    .wrap  (wrap)
  );

  bit_phase_tracker #(
    .TICKS_PER_BIT (TICKS_PER_BIT)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .clear   (align),
    .advance (wrap),
    .phase   (phase)
  );

  term_select #(
    .CNT_W         (CNT_W),
    .SHORT_CNT     (SHORT_CNT),
    .LONG_CNT      (LONG_CNT),
    .SHORT_ON_EVEN (SHORT_ON_EVEN)
  ) u_select (
    .phase (phase),
    .term  (term)
  );

  always_ff @(posedge clk) begin
    if (rst || align) begin
      tick_q <= 1'b0;
    end else begin
      tick_q <= wrap;
    end
  end

  assign tick = tick_q;

endmodule

// File: rtl/frac_tick_gen_checker.sv
module frac_tick_gen_checker #(
  parameter int unsigned SHORT_CNT     = 108,
  parameter int unsigned LONG_CNT      = 109,
  parameter int unsigned TICKS_PER_BIT = 8,
  parameter bit          SHORT_ON_EVEN = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic align,
  input logic tick
);

  localparam int unsigned PAIR  = 2 * TICKS_PER_BIT;
  localparam int unsigned IDX_W = (PAIR > 2) ? $clog2(PAIR) : 1;

  logic [15:0]      gap_q;
  logic [IDX_W-1:0] idx_q;
  int               exp_gap;

  // gap_q: clock edges since the last tick or restart; idx_q: position in the bit pair.
  always_ff @(posedge clk) begin
    if (rst || align) begin
      gap_q <= '0;
      idx_q <= '0;
    end else if (tick) begin
      gap_q <= 16'd1;
      idx_q <= (int'(idx_q) == PAIR - 1) ? '0 : idx_q + IDX_W'(1);
    end else if (gap_q != 16'hFFFF) begin
      gap_q <= gap_q + 16'd1;
    end
  end

  always_comb begin
    if ((int'(idx_q) < TICKS_PER_BIT) == SHORT_ON_EVEN) exp_gap = SHORT_CNT;
    else                                                 exp_gap = LONG_CNT;
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk) rst |=> !tick)
    else $error("R1: tick high after reset cycle");

  a_r2_single_cycle: assert property (@(posedge clk) disable iff (rst) tick |=> !tick)
    else $error("R2: tick wider than one cycle");

  a_r3_r4_gap_pattern: assert property (@(posedge clk) disable iff (rst)
      tick |-> (int'(gap_q) == exp_gap))
    else $error("R3/R4: tick gap %0d, expected %0d", gap_q, exp_gap);

  a_r4_no_late_tick: assert property (@(posedge clk) disable iff (rst)
      int'(gap_q) <= LONG_CNT)
    else $error("R4: gap exceeded long count");

  a_r5_align_silences: assert property (@(posedge clk) disable iff (rst) align |=> !tick)
    else $error("R5/R6: tick right after alignment");

endmodule

bind frac_tick_gen frac_tick_gen_checker #(
  .SHORT_CNT     (SHORT_CNT),
  .LONG_CNT      (LONG_CNT),
  .TICKS_PER_BIT (TICKS_PER_BIT),
  .SHORT_ON_EVEN (SHORT_ON_EVEN)
) u_checker (
  .clk   (clk),
  .rst   (rst),
  .align (align),
  .tick  (tick)
);

// File: tb/frac_tick_gen_bench.sv
module frac_tick_gen_bench;

  localparam int  S     = 108;
  localparam int  L     = 109;
  localparam real IDEAL = 100.0e6 / 921600.0;

  // Expected gap for ticks 1..16 after alignment (bit 0 short, bit 1 long).
  localparam int EXP_GAP [16] = '{S, S, S, S, S, S, S, S, L, L, L, L, L, L, L, L};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic align = 1'b0;
  logic tick;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  frac_tick_gen u_frac_tick_gen (
    .clk   (clk),
    .rst   (rst),
    .align (align),
    .tick  (tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Counts negedges until tick is seen high.
  task automatic measure(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!tick && n < 1000);
  endtask

  task automatic pulse_align();
    align = 1'b1;
    @(negedge clk);
    align = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int g, t, pair_sum;
    bit seen;
    real err;

    // R1: reset state and first tick after release.
    repeat (4) begin
      @(negedge clk);
      check(tick == 1'b0, "R1 reset quiet", int'(tick), 0);
    end
    rst = 1'b0;
    measure(g);
    check(g == S, "R1 first tick after reset", g, S);
    // R2: one-cycle pulse.
    @(negedge clk);
    check(tick == 1'b0, "R2 pulse width", int'(tick), 0);

    // R3/R4: table of expected gaps walked by one loop.
    @(negedge clk);
    pulse_align();
    for (int i = 0; i < 16; i++) begin
      measure(g);
      check(g == EXP_GAP[i], (i < 8) ? "R3 even-bit gap" : "R4 odd-bit gap", g, EXP_GAP[i]);
    end

    // R7/R9: cumulative drift across a 10-bit frame.
    pulse_align();
    t = 0;
    pair_sum = 0;
    for (int k = 1; k <= 80; k++) begin
      measure(g);
      t += g;
      pair_sum += g;
      err = real'(t) - real'(k) * IDEAL;
      if (err < 0.0) err = -err;
      check(err < IDEAL, "R7 cumulative drift", t, int'(real'(k) * IDEAL));
      if (k % 16 == 0) begin
        check(pair_sum >= 16 * S && pair_sum <= 16 * L, "R9 bit-pair total", pair_sum, 16 * S);
        pair_sum = 0;
      end
    end

    // R5: realign in mid-period during an odd bit.
    pulse_align();
    for (int i = 0; i < 12; i++) measure(g);
    repeat (40) @(negedge clk);
    pulse_align();
    for (int i = 0; i < 8; i++) begin
      measure(g);
      check(g == S, "R5 realign restarts even bit", g, S);
    end

    // R6: alignment held high.
    align = 1'b1;
    seen = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (tick) seen = 1'b1;
    end
    check(!seen, "R6 no tick while align held", int'(seen), 0);
    align = 1'b0;
    measure(g);
    check(g == S, "R6 first tick after release", g, S);

    // R8: reset in mid-stream.
    for (int i = 0; i < 3; i++) measure(g);
    repeat (30) @(negedge clk);
    rst = 1'b1;
    seen = 1'b0;
    repeat (200) begin
      @(negedge clk);
      if (tick) seen = 1'b1;
    end
    check(!seen, "R8 no tick during reset", int'(seen), 0);
    rst = 1'b0;
    measure(g);
    check(g == S, "R8 restart after reset", g, S);
    measure(g);
    check(g == S, "R8 second tick after reset", g, S);

    finish_run();
  end

endmodule